// File: doc/BRIEF.md
# Infrared Exposure Mode Sequencer

This block orders the phases of one infrared exposure: array reset, pedestal reads, the integration wait and sample reads. It supports three reset-sample schemes. In single-reset mode each coadd is a reset, a wait and a run of non-destructive sample reads. In double-reset mode a run of pedestal reads comes between the reset and the wait. In correlated double sampling mode every readout frame carries both a sample and a pedestal, and the block runs one readout more than the number of coadds.

For every frame it requests, the block tells a downstream accumulator what to do with the data. It gives one opcode for the sample data and a second opcode for the pedestal data, which is used only in correlated double sampling. An opcode is ignore, write (overwrite the buffer), add or subtract. The readout machinery answers each frame request with a one-cycle frame-done pulse. Settings are captured when go is accepted. An abort ends the run at the next phase boundary.

Top module: `ir_exposure_sequencer`

## Requirements
- R1: After reset, resetReq, frameReq, stampPulse, busy, done and aborted are all low, and both opcodes read ignore (0).
- R2: Mode 0 (single reset) runs, for each coadd, one resetReq cycle, then the wait, then ndr sample frames. The first sample frame of the first coadd gets frameOp write (1). Every other sample frame gets add (2).
- R3: Mode 1 (double reset) runs, for each coadd, one resetReq cycle, then ndr pedestal frames, then the wait, then ndr sample frames. The first pedestal frame of the first coadd gets write (1). Other pedestal frames get subtract (3). Sample frames get add (2).
- R4: Mode 2 (correlated double sampling) runs coadds+1 frames and never raises resetReq. The first frame has frameOp ignore (0) and pedOp subtract (3). The last frame has add (2) and ignore (0). Middle frames have add (2) and subtract (3).
- R5: In modes 0 and 1, each coadd holds max(itime − frame·ndr, 0) + 1 cycles in which busy is high and neither request is. In mode 2, each frame after the first is preceded by max(itime − frame, 0) + 1 such cycles.
- R6: Each accepted go produces exactly one stampPulse cycle. It coincides with the first resetReq cycle in modes 0 and 1, and with the first frameReq cycle in mode 2.
- R7: frameReq stays high until frameDone is sampled, and each frameDone completes exactly one frame. While frameReq is low, both opcodes read ignore (0). pedOp is ignore outside mode 2.
- R8: After the last frame completes, busy falls and done rises in the next cycle. done stays high until the next go, and done and aborted are never high together.
- R9: An abort during the wait or reset phase returns the block to idle in the next cycle. An abort during a frame lets that frame finish and then returns to idle. Either way aborted rises and done stays low.
- R10: A coadds or ndr value of 0 is taken as 1. Mode 3 behaves as mode 0.
- R11: ndr values up to 128 give exactly ndr reads per read phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 single reset, 1 double reset, 2 correlated double sampling, 3 as 0 |
| coadds | input | 16 | Number of coadds, captured at go |
| ndr | input | 8 | Non-destructive reads per read phase, captured at go |
| itimeTicks | input | 32 | Integration time in clock ticks |
| frameTicks | input | 32 | Readout time of one frame in clock ticks |
| go | input | 1 | Start strobe, accepted only while idle |
| abort | input | 1 | Abort strobe |
| frameDone | input | 1 | Readout reports the requested frame finished |
| resetReq | output | 1 | One-cycle array reset request |
| frameReq | output | 1 | Frame readout request, held until frameDone |
| frameOp | output | 2 | Sample-data opcode: 0 ignore, 1 write, 2 add, 3 subtract |
| pedOp | output | 2 | Pedestal-data opcode, same encoding |
| stampPulse | output | 1 | Timestamp strobe at the start of the first coadd |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run completed normally |
| aborted | output | 1 | Last run was ended by abort |

## Verification
Two events can meet in one cycle: an abort that is still pending and the frameDone that closes the current frame, which is also the boundary where the run would otherwise continue or finish. The bench provokes this by raising frameReq, holding frameDone low, pulsing abort, and then releasing frameDone. It judges the result by the request staying high until the release, followed one cycle later by aborted high, done low and no further frame. A second meeting point is the timestamp strobe and the first phase request. Every table run checks that they share a cycle.

// File: rtl/irseq_pkg.sv
package irseq_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_DOUBLE = 2'd1,
    MODE_CDS    = 2'd2,
    MODE_RSVD   = 2'd3
  } seqMode_t;

  typedef enum logic [1:0] {
    OP_IGNORE = 2'd0,
    OP_WRITE  = 2'd1,
    OP_ADD    = 2'd2,
    OP_SUB    = 2'd3
  } accOp_t;

  // strobes from control to the counter datapath
  typedef struct packed {
    logic latch;
    logic clrRead;
    logic incRead;
    logic clrCoadd;
    logic incCoadd;
    logic loadWait;
    logic decWait;
  } seqStrobe_t;

  // status from the datapath back to control
  typedef struct packed {
    seqMode_t mode;
    logic     firstRead;
    logic     lastRead;
    logic     firstCoadd;
    logic     lastArcCoadd;
    logic     lastCdsCoadd;
    logic     waitZero;
  } seqStatus_t;

endpackage

// File: rtl/irseq_counters.sv
module irseq_counters
  import irseq_pkg::*;
#(
  parameter int COADD_W = 16,
  parameter int NDR_W   = 8,
  parameter int TIME_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         stb,
  input  logic [1:0]         modeIn,
  input  logic [COADD_W-1:0] coaddsIn,
  input  logic [NDR_W-1:0]   ndrIn,
  input  logic [TIME_W-1:0]  itimeIn,
  input  logic [TIME_W-1:0]  frameIn,
  output seqStatus_t         status
);

  localparam int PROD_W = TIME_W + NDR_W;

  seqMode_t           modeQ;
  logic [COADD_W-1:0] coaddsEff;
  logic [NDR_W-1:0]   ndrEff;
  logic [TIME_W-1:0]  itimeQ;
  logic [TIME_W-1:0]  frameQ;
  logic [NDR_W-1:0]   readIdx;
  logic [COADD_W-1:0] coaddIdx;
  logic [TIME_W-1:0]  waitCnt;

  logic [PROD_W-1:0]  readSpan;
  logic [PROD_W-1:0]  itimeWide;
  logic [TIME_W-1:0]  arcWait;
  logic [TIME_W-1:0]  cdsWait;

  // integration wait: arc modes subtract all reads, cds subtracts one frame
  always_comb begin
    readSpan  = PROD_W'(frameQ) * PROD_W'(ndrEff);
    itimeWide = PROD_W'(itimeQ);
    arcWait   = (itimeWide > readSpan) ? TIME_W'(itimeWide - readSpan) : '0;
    cdsWait   = (itimeQ > frameQ) ? (itimeQ - frameQ) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ     <= MODE_SINGLE;
      coaddsEff <= COADD_W'(1);
      ndrEff    <= NDR_W'(1);
      itimeQ    <= '0;
      frameQ    <= '0;
    end else if (stb.latch) begin
      modeQ     <= (modeIn == MODE_RSVD) ? MODE_SINGLE : seqMode_t'(modeIn);
      coaddsEff <= (coaddsIn == '0) ? COADD_W'(1) : coaddsIn;
      ndrEff    <= (ndrIn == '0) ? NDR_W'(1) : ndrIn;
      itimeQ    <= itimeIn;
      frameQ    <= frameIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readIdx  <= '0;
      coaddIdx <= '0;
      waitCnt  <= '0;
    end else begin
      if (stb.clrRead)       readIdx <= '0;
      else if (stb.incRead)  readIdx <= readIdx + NDR_W'(1);
      if (stb.clrCoadd)      coaddIdx <= '0;
      else if (stb.incCoadd) coaddIdx <= coaddIdx + COADD_W'(1);
      if (stb.loadWait)      waitCnt <= (modeQ == MODE_CDS) ? cdsWait : arcWait;
      else if (stb.decWait)  waitCnt <= waitCnt - TIME_W'(1);
    end
  end

  always_comb begin
    status.mode         = modeQ;
    status.firstRead    = (readIdx == '0);
    status.lastRead     = (readIdx == ndrEff - NDR_W'(1));
    status.firstCoadd   = (coaddIdx == '0);
    status.lastArcCoadd = (coaddIdx == coaddsEff - COADD_W'(1));
    status.lastCdsCoadd = (coaddIdx == coaddsEff);
    status.waitZero     = (waitCnt == '0);
  end

  // each decrement strobe removes exactly one tick from the wait
  p_wait_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.decWait |=> waitCnt == $past(waitCnt) - TIME_W'(1));

  // the read index never runs past the read count
  p_read_range_r11: assert property (@(posedge clk) disable iff (!rstN)
    !stb.latch |-> readIdx < ndrEff);

endmodule

// File: rtl/irseq_fsm.sv
module irseq_fsm
  import irseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       go,
  input  logic       abort,
  input  logic [1:0] modeIn,
  input  logic       frameDone,
  input  seqStatus_t status,
  output seqStrobe_t stb,
  output logic       resetReq,
  output logic       frameReq,
  output accOp_t     frameOp,
  output accOp_t     pedOp,
  output logic       stampPulse,
  output logic       busy,
  output logic       done,
  output logic       aborted
);

  typedef enum logic [2:0] {
    S_IDLE, S_RESET, S_PED, S_WAIT, S_SAMP, S_CREAD
  } phase_t;

  phase_t state, nxt;
  logic   abortPend;
  logic   abortHit;
  logic   finDone;
  logic   finAbort;
  logic   goAccept;

  assign abortHit = abort | abortPend;
  assign goAccept = (state == S_IDLE) && go;

  always_comb begin
    nxt      = state;
    stb      = '0;
    finDone  = 1'b0;
    finAbort = 1'b0;
    unique case (state)
      S_IDLE: if (go) begin
        stb.latch    = 1'b1;
        stb.clrRead  = 1'b1;
        stb.clrCoadd = 1'b1;
        nxt = (modeIn == MODE_CDS) ? S_CREAD : S_RESET;
      end
      S_RESET: begin
        if (abortHit) finAbort = 1'b1;
        else if (status.mode == MODE_DOUBLE) begin
          nxt         = S_PED;
          stb.clrRead = 1'b1;
        end else begin
          nxt          = S_WAIT;
          stb.loadWait = 1'b1;
        end
      end
      S_PED: if (frameDone) begin
        if (abortHit) finAbort = 1'b1;
        else if (status.lastRead) begin
          nxt          = S_WAIT;
          stb.loadWait = 1'b1;
        end else stb.incRead = 1'b1;
      end
      S_WAIT: begin
        if (abortHit) finAbort = 1'b1;
        else if (status.waitZero) begin
          if (status.mode == MODE_CDS) nxt = S_CREAD;
          else begin
            nxt         = S_SAMP;
            stb.clrRead = 1'b1;
          end
        end else stb.decWait = 1'b1;
      end
      S_SAMP: if (frameDone) begin
        if (abortHit) finAbort = 1'b1;
        else if (status.lastRead) begin
          if (status.lastArcCoadd) finDone = 1'b1;
          else begin
            stb.incCoadd = 1'b1;
            nxt          = S_RESET;
          end
        end else stb.incRead = 1'b1;
      end
      S_CREAD: if (frameDone) begin
        if (abortHit) finAbort = 1'b1;
        else if (status.lastCdsCoadd) finDone = 1'b1;
        else begin
          stb.incCoadd = 1'b1;
          stb.loadWait = 1'b1;
          nxt          = S_WAIT;
        end
      end
      default: nxt = S_IDLE;
    endcase
    if (finDone || finAbort) nxt = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      abortPend  <= 1'b0;
      done       <= 1'b0;
      aborted    <= 1'b0;
      stampPulse <= 1'b0;
    end else begin
      state      <= nxt;
      stampPulse <= goAccept;
      if (goAccept) begin
        done      <= 1'b0;
        aborted   <= 1'b0;
        abortPend <= 1'b0;
      end else if (finAbort) begin
        aborted   <= 1'b1;
        abortPend <= 1'b0;
      end else if (finDone) begin
        done <= 1'b1;
      end else if (abort && state != S_IDLE) begin
        abortPend <= 1'b1;
      end
    end
  end

  always_comb begin
    resetReq = (state == S_RESET);
    frameReq = (state == S_PED) || (state == S_SAMP) || (state == S_CREAD);
    busy     = (state != S_IDLE);
    frameOp  = OP_IGNORE;
    pedOp    = OP_IGNORE;
    unique case (state)
      S_PED:  frameOp = (status.firstCoadd && status.firstRead) ? OP_WRITE : OP_SUB;
      S_SAMP: frameOp = (status.mode == MODE_SINGLE && status.firstCoadd &&
                         status.firstRead) ? OP_WRITE : OP_ADD;
      S_CREAD: begin
        frameOp = status.firstCoadd ? OP_IGNORE : OP_ADD;
        pedOp   = status.lastCdsCoadd ? OP_IGNORE : OP_SUB;
      end
      default: ;
    endcase
  end

  p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(done && aborted));

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_reset_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

  p_stamp_phase_r6: assert property (@(posedge clk) disable iff (!rstN)
    stampPulse |-> (resetReq || frameReq));

  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(aborted) |-> !busy && !frameReq);

  p_frame_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (frameReq && !frameDone) |=> frameReq);

endmodule

// File: rtl/ir_exposure_sequencer.sv
module ir_exposure_sequencer
  import irseq_pkg::*;
#(
  parameter int COADD_W = 16,
  parameter int NDR_W   = 8,
  parameter int TIME_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         mode,
  input  logic [COADD_W-1:0] coadds,
  input  logic [NDR_W-1:0]   ndr,
  input  logic [TIME_W-1:0]  itimeTicks,
  input  logic [TIME_W-1:0]  frameTicks,
  input  logic               go,
  input  logic               abort,
  input  logic               frameDone,
  output logic               resetReq,
  output logic               frameReq,
  output logic [1:0]         frameOp,
  output logic [1:0]         pedOp,
  output logic               stampPulse,
  output logic               busy,
  output logic               done,
  output logic               aborted
);

  seqStrobe_t stb;
  seqStatus_t status;
  accOp_t     frameOpE;
  accOp_t     pedOpE;

  irseq_counters #(
    .COADD_W(COADD_W), .NDR_W(NDR_W), .TIME_W(TIME_W)
  ) counters_i (
    .clk(clk), .rstN(rstN), .stb(stb), .modeIn(mode), .coaddsIn(coadds),
    .ndrIn(ndr), .itimeIn(itimeTicks), .frameIn(frameTicks), .status(status)
  );

  irseq_fsm fsm_i (
    .clk(clk), .rstN(rstN), .go(go), .abort(abort), .modeIn(mode),
    .frameDone(frameDone), .status(status), .stb(stb), .resetReq(resetReq),
    .frameReq(frameReq), .frameOp(frameOpE), .pedOp(pedOpE),
    .stampPulse(stampPulse), .busy(busy), .done(done), .aborted(aborted)
  );

  assign frameOp = frameOpE;
  assign pedOp   = pedOpE;

  p_ops_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !frameReq |-> (frameOp == 2'd0 && pedOp == 2'd0));

endmodule

// File: tb/ir_exposure_sequencer_tb.sv
module ir_exposure_sequencer_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  mode = '0;
  logic [15:0] coadds = '0;
  logic [7:0]  ndr = '0;
  logic [31:0] itimeTicks = '0;
  logic [31:0] frameTicks = '0;
  logic        go = 1'b0;
  logic        abort = 1'b0;
  logic        frameDone = 1'b0;
  logic        resetReq, frameReq, stampPulse, busy, done, aborted;
  logic [1:0]  frameOp, pedOp;

  int checks = 0;
  int errors = 0;

  ir_exposure_sequencer dut_i (
    .clk(clk), .rstN(rstN), .mode(mode), .coadds(coadds), .ndr(ndr),
    .itimeTicks(itimeTicks), .frameTicks(frameTicks), .go(go), .abort(abort),
    .frameDone(frameDone), .resetReq(resetReq), .frameReq(frameReq),
    .frameOp(frameOp), .pedOp(pedOp), .stampPulse(stampPulse), .busy(busy),
    .done(done), .aborted(aborted)
  );

  always #2 clk = ~clk;

  typedef struct packed {
    logic [1:0]  md;
    logic [15:0] nc;
    logic [7:0]  nd;
    logic [31:0] it;
    logic [31:0] ft;
    int          expFrames;
    int          expResets;
    int          expWaits;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 16'd2, 8'd2,   32'd20, 32'd3, 4,   2, 30},
    '{2'd1, 16'd2, 8'd3,   32'd30, 32'd2, 12,  2, 50},
    '{2'd2, 16'd3, 8'd5,   32'd10, 32'd4, 4,   0, 21},
    '{2'd0, 16'd1, 8'd1,   32'd1,  32'd5, 1,   1, 1},
    '{2'd1, 16'd1, 8'd1,   32'd0,  32'd0, 2,   1, 1},
    '{2'd2, 16'd1, 8'd1,   32'd3,  32'd7, 2,   0, 1},
    '{2'd1, 16'd0, 8'd0,   32'd5,  32'd1, 2,   1, 5},
    '{2'd0, 16'd1, 8'd128, 32'd0,  32'd1, 128, 1, 1},
    '{2'd3, 16'd1, 8'd1,   32'd2,  32'd1, 1,   1, 2}
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // opcodes: 0 ignore, 1 write, 2 add, 3 subtract; returns {frameOp, pedOp}
  function automatic logic [3:0] modelOps(input int mdIn, input int ncIn,
                                          input int ndIn, input int k);
    int md, nc, nd, per, c, r, s;
    md = (mdIn == 3) ? 0 : mdIn;
    nc = (ncIn == 0) ? 1 : ncIn;
    nd = (ndIn == 0) ? 1 : ndIn;
    if (md == 2) begin
      if (k == 0)  return {2'd0, 2'd3};
      if (k == nc) return {2'd2, 2'd0};
      return {2'd2, 2'd3};
    end
    per = (md == 1) ? 2 * nd : nd;
    c = k / per;
    r = k % per;
    if (md == 1 && r < nd) return {((c == 0 && r == 0) ? 2'd1 : 2'd3), 2'd0};
    s = (md == 1) ? r - nd : r;
    return {((md == 0 && c == 0 && s == 0) ? 2'd1 : 2'd2), 2'd0};
  endfunction

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog run did not finish actual=1 expected=0");
    finishRun();
  end

  task automatic runVec(input vec_t v, input int idx);
    int frames = 0, resets = 0, waits = 0, stamps = 0, opBad = 0, dly = 0;
    logic stampOk = 1'b1;
    logic [3:0] expOp;
    mode = v.md; coadds = v.nc; ndr = v.nd; itimeTicks = v.it; frameTicks = v.ft;
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    while (!done && !aborted) begin
      if (stampPulse) begin
        stamps++;
        if (v.md == 2'd2) stampOk = stampOk & frameReq & ~resetReq;
        else              stampOk = stampOk & resetReq & ~frameReq;
      end
      if (resetReq) resets++;
      if (busy && !resetReq && !frameReq) waits++;
      frameDone = 1'b0;
      if (frameReq) begin
        if (dly == 1) begin
          expOp = modelOps(int'(v.md), int'(v.nc), int'(v.nd), frames);
          if ({frameOp, pedOp} != expOp) begin
            opBad++;
            if (opBad == 1)
              $display("FAIL R2/R3/R4 vec %0d frame %0d ops actual=%0d expected=%0d",
                       idx, frames, {frameOp, pedOp}, expOp);
          end
          frames++;
          frameDone = 1'b1;
          dly = 0;
        end else dly++;
      end
      @(negedge clk);
    end
    frameDone = 1'b0;
    check(opBad == 0, "R2 R3 R4 opcode sequence", opBad, 0);
    check(frames == v.expFrames, "R11 R10 frame count", frames, v.expFrames);
    check(resets == v.expResets, "R2 R3 R4 reset count", resets, v.expResets);
    check(waits == v.expWaits, "R5 wait cycles", waits, v.expWaits);
    check(stamps == 1 && stampOk, "R6 timestamp strobe", stamps, 1);
    check(done && !aborted && !busy, "R8 completion flags", {done, aborted, busy}, 3'b100);
    repeat (3) @(negedge clk);
    check(done && !aborted, "R8 done held", done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({resetReq, frameReq, stampPulse, busy, done, aborted} == '0,
          "R1 reset outputs", {resetReq, frameReq, stampPulse, busy, done, aborted}, 0);
    check({frameOp, pedOp} == '0, "R1 reset opcodes", {frameOp, pedOp}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done, "R1 idle after release", {busy, done}, 0);

    for (int i = 0; i < NVEC; i++) runVec(VECS[i], i);

    // abort during a long wait: idle next cycle
    mode = 2'd0; coadds = 16'd3; ndr = 8'd1; itimeTicks = 32'd1000; frameTicks = 32'd1;
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    repeat (5) @(negedge clk);
    check(busy && !frameReq && !resetReq, "R9 in wait before abort", busy, 1);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    check(aborted && !busy && !done, "R9 abort in wait", {aborted, busy, done}, 3'b100);
    repeat (2) @(negedge clk);
    check(!frameReq && !resetReq, "R9 nothing after abort", {frameReq, resetReq}, 0);

    // abort during a frame: frame finishes first
    mode = 2'd1; coadds = 16'd2; ndr = 8'd2; itimeTicks = 32'd10; frameTicks = 32'd1;
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    while (!frameReq) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    repeat (2) @(negedge clk);
    check(frameReq && !aborted, "R9 frame held across abort", {frameReq, aborted}, 2'b10);
    frameDone = 1'b1;
    @(negedge clk);
    frameDone = 1'b0;
    check(aborted && !done && !busy && !frameReq, "R9 abort at frame end",
          {aborted, done, busy, frameReq}, 4'b1000);

    // a normal run after an abort clears the flag and completes
    runVec(VECS[0], 0);

    finishRun();
  end

endmodule